// File: doc/BRIEF.md
# Clock Startup and Lock Controller

This block owns the main system clock of a chip right after reset. Three clock-control registers live here: one control word and two PLL configuration words. Writing the control word arms a programmable divider fed by either the reference clock tick or the PLL clock tick. It also arms a startup timer. The divided clock enable is held off until the divider has produced a programmed number of pulses, so that the analogue parts upstream have time to settle. From the moment the control word is written, all three clock registers are frozen until reset.

Until the clock runs, the block refuses every register-bus access except those to its own clock registers, its status register and a general-reset command address. Refused reads return zero, and refused accesses are not forwarded to the rest of the chip. Once the clock runs, accesses to other addresses are passed on through `bus_pass_o`. Both source clocks arrive as single-cycle tick strobes in the bus clock domain, and the output is a clock-enable strobe in that same domain.

Top module: `clk_startup_ctrl`

## Requirements
- R1: After reset, `sys_clk_en_o`, `done_o`, `amp_en_o` and `bus_pass_o` are 0, and reads of CTRL (0x01), PLL_CFG0 (0x02), PLL_CFG1 (0x03) and STATUS (0x04) return 0.
- R2: While the clock is not running, an access to any address other than 0x01..0x05 is not forwarded (`bus_pass_o`=0) and reads 0. Once the clock runs, such an access sets `bus_pass_o` during its cycle.
- R3: Addresses 0x01..0x05 can be written and read before the clock runs.
- R4: The CTRL layout is: bit 0 reference-amplifier enable (drives `amp_en_o`), bits 7:1 divide ratio, bits 12:8 startup exponent N, bit 13 done enable. Bits 15:14 are reserved, are dropped on write and read back as 0.
- R5: PLL_CFG0 bit 0 selects the divider source: 0 selects `ref_tick_i` and 1 selects `pll_tick_i`. Ticks on the unselected input have no effect.
- R6: The divider emits one pulse every D selected ticks, where D is the CTRL divide field. A field value of 0 divides by 1.
- R7: `sys_clk_en_o` stays 0 for the first 2^N divider pulses. Every divider pulse after those appears on `sys_clk_en_o`, in the cycle after the tick that completes it.
- R8: STATUS reads as {13'b0, locked, running, done}, where done = running AND CTRL bit 13. `done_o` carries the same done value.
- R9: Once CTRL has been written, later writes to CTRL, PLL_CFG0 and PLL_CFG1 have no effect until reset.
- R10: A write to the general-reset address 0x05 returns the block to its reset state at the next clock edge. This clears the write lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and control clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid_i | input | 1 | Access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data (combinational, 0 for refused or foreign addresses) |
| bus_pass_o | output | 1 | Access forwarded to the rest of the chip |
| ref_tick_i | input | 1 | Reference clock tick strobe |
| pll_tick_i | input | 1 | PLL clock tick strobe |
| sys_clk_en_o | output | 1 | Gated system clock enable strobe |
| amp_en_o | output | 1 | Reference amplifier enable |
| done_o | output | 1 | Startup-done flag |

## Verification
If the divider count or the startup count is wrong, the first `sys_clk_en_o` strobe lands on the wrong tick index. The scoreboard therefore compares every strobe against its exact tick index, so an off-by-one shows up at the first strobe. A broken write lock or a leaky bus gate shows up at the next readback or the next foreign access, within one bus cycle. A broken source select shows up as a strobe sequence that tracks the wrong tick input.

// File: rtl/clk_startup_pkg.sv
package clk_startup_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 8;
    localparam int DIV_W  = 7;
    localparam int DLY_W  = 5;
    localparam int CNT_W  = 1 << DLY_W;

    localparam logic [ADDR_W-1:0] A_CTRL   = 8'h01;
    localparam logic [ADDR_W-1:0] A_PLL0   = 8'h02;
    localparam logic [ADDR_W-1:0] A_PLL1   = 8'h03;
    localparam logic [ADDR_W-1:0] A_STATUS = 8'h04;
    localparam logic [ADDR_W-1:0] A_GENRST = 8'h05;

    typedef struct packed {
        logic [1:0]       rsvd;
        logic             done_en;
        logic [DLY_W-1:0] dly_exp;
        logic [DIV_W-1:0] div;
        logic             amp_en;
    } ctrl_t;

    function automatic logic is_local(input logic [ADDR_W-1:0] a);
        return (a >= A_CTRL) && (a <= A_GENRST);
    endfunction

    function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
        return (d == '0) ? DIV_W'(1) : d;
    endfunction
endpackage

// File: rtl/clk_reg_bank.sv
module clk_reg_bank
    import clk_startup_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              running_i,
    input  logic              done_i,
    output logic              clear_o,
    output ctrl_t             ctrl_o,
    output logic              pll_sel_o,
    output logic              locked_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              pass_o
);
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] pll0_q, pll1_q;
    logic              locked_q;
    logic              wr, rd;

    assign wr      = bus_valid_i && bus_we_i;
    assign rd      = bus_valid_i && !bus_we_i;
    assign clear_o = rst || (wr && bus_addr_i == A_GENRST);

    always_ff @(posedge clk) begin
        if (clear_o) begin
            ctrl_q   <= '0;
            pll0_q   <= '0;
            pll1_q   <= '0;
            locked_q <= 1'b0;
        end else if (wr && !locked_q) begin
            case (bus_addr_i)
                A_CTRL: begin
                    ctrl_q      <= ctrl_t'(bus_wdata_i);
                    ctrl_q.rsvd <= 2'b00;
                    locked_q    <= 1'b1;
                end
                A_PLL0:  pll0_q <= bus_wdata_i;
                A_PLL1:  pll1_q <= bus_wdata_i;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd) begin
            case (bus_addr_i)
                A_CTRL:   rdata_o = DATA_W'(ctrl_q);
                A_PLL0:   rdata_o = pll0_q;
                A_PLL1:   rdata_o = pll1_q;
                A_STATUS: rdata_o = {{(DATA_W-3){1'b0}}, locked_q, running_i, done_i};
                default:  rdata_o = '0;
            endcase
        end
    end

    assign pass_o    = bus_valid_i && running_i && !is_local(bus_addr_i);
    assign ctrl_o    = ctrl_q;
    assign pll_sel_o = pll0_q[0];
    assign locked_o  = locked_q;

    assert_ctrl_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (locked_q && $past(locked_q)) |-> ($stable(ctrl_q) && $stable(pll0_q) && $stable(pll1_q)));
    assert_run_needs_lock_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(running_i) |-> locked_q);
    assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.rsvd == 2'b00);
endmodule

// File: rtl/clk_src_divider.sv
module clk_src_divider
    import clk_startup_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             en_i,
    input  logic             pll_sel_i,
    input  logic             ref_tick_i,
    input  logic             pll_tick_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             pulse_o
);
    logic [DIV_W-1:0] cnt_q;
    logic             pulse_q;
    logic             tick;
    logic [DIV_W-1:0] last;

    assign tick = pll_sel_i ? pll_tick_i : ref_tick_i;
    assign last = eff_div(div_i) - DIV_W'(1);

    always_ff @(posedge clk) begin
        if (clear_i || !en_i) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else if (tick) begin
            if (cnt_q >= last) begin
                cnt_q   <= '0;
                pulse_q <= 1'b1;
            end else begin
                cnt_q   <= cnt_q + DIV_W'(1);
                pulse_q <= 1'b0;
            end
        end else begin
            pulse_q <= 1'b0;
        end
    end

    assign pulse_o = pulse_q;

    assert_pulse_needs_tick_R6: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> $past(en_i && (pll_sel_i ? pll_tick_i : ref_tick_i)));
    assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (rst)
        $past(en_i && !clear_i) |-> (cnt_q <= $past(last)) || $past(div_i) != div_i);
endmodule

// File: rtl/clk_startup_timer.sv
module clk_startup_timer
    import clk_startup_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             en_i,
    input  logic             pulse_i,
    input  logic [DLY_W-1:0] dly_exp_i,
    output logic             running_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             running_q;
    logic [CNT_W-1:0] limit;

    assign limit = (CNT_W'(1) << dly_exp_i) - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (clear_i || !en_i) begin
            cnt_q     <= '0;
            running_q <= 1'b0;
        end else if (pulse_i && !running_q) begin
            if (cnt_q == limit) running_q <= 1'b1;
            else                cnt_q     <= cnt_q + CNT_W'(1);
        end
    end

    assign running_o = running_q;

    assert_run_after_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(running_q) |-> $past(pulse_i));
    assert_run_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(running_q) && $past(en_i) && !$past(clear_i)) |-> running_q);
endmodule

// File: rtl/clk_startup_ctrl.sv
module clk_startup_ctrl
    import clk_startup_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_valid_i,
    input  logic        bus_we_i,
    input  logic [7:0]  bus_addr_i,
    input  logic [15:0] bus_wdata_i,
    output logic [15:0] bus_rdata_o,
    output logic        bus_pass_o,
    input  logic        ref_tick_i,
    input  logic        pll_tick_i,
    output logic        sys_clk_en_o,
    output logic        amp_en_o,
    output logic        done_o
);
    ctrl_t ctrl;
    logic  clear, pll_sel, locked, running, pulse, done;

    assign done = running && ctrl.done_en;

    clk_reg_bank u_regs (
        .clk(clk), .rst(rst),
        .bus_valid_i(bus_valid_i), .bus_we_i(bus_we_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .running_i(running), .done_i(done),
        .clear_o(clear), .ctrl_o(ctrl), .pll_sel_o(pll_sel),
        .locked_o(locked), .rdata_o(bus_rdata_o), .pass_o(bus_pass_o)
    );

    clk_src_divider u_div (
        .clk(clk), .rst(rst), .clear_i(clear), .en_i(locked),
        .pll_sel_i(pll_sel), .ref_tick_i(ref_tick_i), .pll_tick_i(pll_tick_i),
        .div_i(ctrl.div), .pulse_o(pulse)
    );

    clk_startup_timer u_tmr (
        .clk(clk), .rst(rst), .clear_i(clear), .en_i(locked),
        .pulse_i(pulse), .dly_exp_i(ctrl.dly_exp), .running_o(running)
    );

    assign sys_clk_en_o = pulse && running;
    assign amp_en_o     = ctrl.amp_en;
    assign done_o       = done;

    assert_clk_needs_lock_R7: assert property (@(posedge clk) disable iff (rst)
        sys_clk_en_o |-> locked);
    assert_pass_needs_clock_R2: assert property (@(posedge clk) disable iff (rst)
        bus_pass_o |-> $past(pulse) || running);
endmodule

// File: tb/clk_startup_ctrl_tb_top.sv
module clk_startup_ctrl_tb_top;
    logic        clk = 0, rst = 1;
    logic        bus_valid_i = 0, bus_we_i = 0;
    logic [7:0]  bus_addr_i = 0;
    logic [15:0] bus_wdata_i = 0;
    logic [15:0] bus_rdata_o;
    logic        bus_pass_o, ref_tick_i = 0, pll_tick_i = 0;
    logic        sys_clk_en_o, amp_en_o, done_o;

    int n_chk = 0, n_fail = 0;
    int exp_q[$];
    int nticks = 0;
    bit counting = 0, use_pll = 0;

    clk_startup_ctrl dut_i (.*);

    always #2 clk = ~clk;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) if (counting && (use_pll ? pll_tick_i : ref_tick_i)) nticks++;

    always @(posedge clk) begin
        #1;
        if (sys_clk_en_o) begin
            if (exp_q.size() == 0) check("R7 unexpected strobe", nticks, -1);
            else check("R7 strobe tick index", nticks, exp_q.pop_front());
        end
    end

    task automatic do_reset();
        @(negedge clk); rst = 1; counting = 0; nticks = 0; exp_q.delete();
        ref_tick_i = 0; pll_tick_i = 0;
        @(negedge clk); @(negedge clk); rst = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk); bus_valid_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk); bus_valid_i = 0; bus_we_i = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d, output logic p);
        @(negedge clk); bus_valid_i = 1; bus_we_i = 0; bus_addr_i = a;
        #1; d = bus_rdata_o; p = bus_pass_o;
        @(negedge clk); bus_valid_i = 0;
    endtask

    // push expected strobes: the j-th strobe lands at tick D*(2^N + j)
    task automatic start_run(input int d, input int n, input int strobes);
        int de = (d == 0) ? 1 : d;
        for (int j = 1; j <= strobes; j++) exp_q.push_back(de * ((1 << n) + j));
        nticks = 0; counting = 1;
    endtask

    // drive selected ticks every 'gap' cycles until 'total' selected ticks driven
    task automatic drive(input int total, input int gap, input bit other);
        int sent = 0, ph = 0;
        while (sent < total) begin
            @(negedge clk);
            if (ph == 0) begin
                if (use_pll) pll_tick_i = 1; else ref_tick_i = 1;
                sent++;
            end else begin
                if (use_pll) pll_tick_i = 0; else ref_tick_i = 0;
            end
            if (other) begin
                if (use_pll) ref_tick_i = 1; else pll_tick_i = 1;
            end
            ph = (ph + 1 == gap) ? 0 : ph + 1;
        end
        @(negedge clk); ref_tick_i = 0; pll_tick_i = 0;
        repeat (4) @(negedge clk);
    endtask

    logic [15:0] rv; logic pv;

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                check("watchdog", 0, 1);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        join_none

        // R1 reset state
        do_reset();
        check("R1 sys_clk_en", sys_clk_en_o, 0);
        check("R1 done", done_o, 0);
        check("R1 amp", amp_en_o, 0);
        rd(8'h01, rv, pv); check("R1 ctrl", rv, 0);
        rd(8'h04, rv, pv); check("R1 status", rv, 0);

        // Phase A: reference, D=3, N=2, done enabled, amp on, reserved bits set
        wr(8'h40, 16'h1234); // foreign write before run
        rd(8'h40, rv, pv);
        check("R2 foreign read before run", rv, 0);
        check("R2 no pass before run", pv, 0);
        wr(8'h03, 16'h5A5A);
        rd(8'h03, rv, pv); check("R3 pll_cfg1 before run", rv, 16'h5A5A);
        use_pll = 0;
        wr(8'h01, 16'hC000 | (1 << 13) | (2 << 8) | (3 << 1) | 1);
        start_run(3, 2, 3);
        rd(8'h01, rv, pv); check("R4 ctrl readback reserved cleared", rv, 16'h2207);
        check("R4 amp enable", amp_en_o, 1);
        rd(8'h04, rv, pv); check("R8 status locked only", rv, 16'h0004);
        drive(21, 1, 1'b1);
        check("R7 strobes consumed", exp_q.size(), 0);
        rd(8'h04, rv, pv); check("R8 status running+done", rv, 16'h0007);
        check("R8 done_o", done_o, 1);
        rd(8'h40, rv, pv); check("R2 pass after run", pv, 1);
        wr(8'h01, 16'h0000);
        wr(8'h02, 16'h0001);
        wr(8'h03, 16'h0000);
        rd(8'h01, rv, pv); check("R9 ctrl unchanged", rv, 16'h2207);
        rd(8'h02, rv, pv); check("R9 pll_cfg0 unchanged", rv, 0);
        rd(8'h03, rv, pv); check("R9 pll_cfg1 unchanged", rv, 16'h5A5A);

        // R10 general reset
        wr(8'h05, 16'h0000);
        check("R10 clock stopped", sys_clk_en_o, 0);
        rd(8'h04, rv, pv); check("R10 status cleared", rv, 0);
        rd(8'h01, rv, pv); check("R10 ctrl cleared", rv, 0);
        counting = 0;
        drive(10, 1, 1'b0); // no strobes expected
        wr(8'h01, 16'h0004);
        rd(8'h01, rv, pv); check("R10 lock released", rv, 16'h0004);

        // Phase B: PLL source, D=0 (as 1), N=1, done disabled, ref ticks noise
        do_reset();
        use_pll = 1;
        wr(8'h02, 16'h0001);
        wr(8'h03, 16'hABCD);
        wr(8'h01, (1 << 8));
        start_run(0, 1, 3);
        drive(5, 2, 1'b1);
        check("R5 R6 pll strobes consumed", exp_q.size(), 0);
        rd(8'h04, rv, pv); check("R8 done disabled", rv, 16'h0006);
        check("R8 done_o low", done_o, 0);

        // Phase C: reference, D=2, N=0, sparse ticks, PLL noise ignored
        do_reset();
        use_pll = 0;
        wr(8'h01, (1 << 13) | (2 << 1));
        start_run(2, 0, 2);
        drive(6, 3, 1'b1);
        check("R6 R7 N=0 strobes consumed", exp_q.size(), 0);
        rd(8'h04, rv, pv); check("R8 running+done", rv, 16'h0007);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule